// File: doc/BRIEF.md
# Two-Tier Masked Interrupt Controller

This block collects event requests from several sources and merges them into one interrupt request line for a small processor core. Three core-class sources are built in: a selectable edge on an external pin, a change on a four-pin port group, and a rollover pulse from an 8/16-bit timer. The timer counting logic lies outside the block and delivers its wrap from 0xFF or 0xFFFF to zero as a one-cycle pulse. In addition there is a parameterised number of peripheral-class event lines. Each event sets a sticky flag that stays set until software clears it.

Two layers of masking decide whether a set flag raises the request. The first layer is a local enable per source. The second layer is a global enable, which gates every source. A peripheral-group enable also gates the peripheral-class sources. Software uses a small register port to read the flags, clear them by writing zeros, program the enables and the edge select, and read the synchronised port pins. Reading the port pins also re-arms the port-change detector.

Top module: `intc_two_tier`

## Requirements
- R1: A flag, once set by its event, stays set after the event condition is gone, until software clears it. Flag bit positions: 0 external pin, 1 port change, 2 timer rollover, 3 and up peripheral lines in index order.
- R2: A set flag whose local enable is zero never drives `irq` high. Local enables sit at the same bit positions of the control register (address 1) as the flags.
- R3: While the global enable (control bit NSRC+2) is zero, `irq` stays low, and events still set their flags.
- R4: A core-class source drives `irq` high when its flag, its local enable and the global enable are all one. The peripheral-group enable has no effect on it.
- R5: A peripheral-class source drives `irq` high only when its flag, its local enable, the global enable and the peripheral-group enable (control bit NSRC+1) are all one.
- R6: A write to the flag register (address 0) clears each flag whose data bit is zero and leaves each flag whose data bit is one unchanged.
- R7: When an event and a software clear of the same flag fall in the same cycle, the flag ends up set.
- R8: The external-pin flag is set on a rising edge when control bit NSRC is one and on a falling edge when it is zero. The opposite edge has no effect. The pin passes through a two-flop synchroniser first.
- R9: The port-change flag is set while the synchronised port differs from a reference. The reference is loaded with the synchronised port on each read of address 2, and that read returns the synchronised port value.
- R10: `irq` is a register that goes high one cycle after a qualifying flag-and-enable condition appears. It stays high as long as that condition holds and falls one cycle after it ends.
- R11: After reset all flags, enables, the port reference and `irq` are zero. Reads of the control register return the stored bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ext_pin | input | 1 | Asynchronous external event pin |
| port_pins | input | 4 | Asynchronous port group watched for changes |
| tmr_wrap | input | 1 | One-cycle timer rollover pulse |
| periph_evt | input | NPER | Peripheral event lines, high sets the flag |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address: 0 flags, 1 control, 2 port |
| reg_wdata | input | NSRC+3 | Write data |
| reg_rdata | output | NSRC+3 | Read data for the addressed register |
| irq | output | 1 | Registered interrupt request |

## Verification
A flag that fails to stick, or a flag cleared by a one-bit write, appears on the flag readback at the next read. If the enable logic is set up wrong, the error shows on `irq` one cycle after the flag sets: either the line rises when a mask should hold it low, or it stays low when it should rise. A port reference that fails to load on a read shows up as a port-change flag that comes straight back after every clear. A wrong edge polarity shows up as an external-pin flag after the wrong transition, three cycles after the pin moves.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int CORE_SRCS = 3;
  localparam int SRC_EXT   = 0;
  localparam int SRC_PORT  = 1;
  localparam int SRC_TMR   = 2;
  localparam int PORT_W    = 4;
  localparam int ADDR_W    = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADR_FLAGS = 2'd0,
    ADR_CTRL  = 2'd1,
    ADR_PORT  = 2'd2,
    ADR_NONE  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d_async;
      stab_q <= meta_q;
    end
  end

  assign q_sync = stab_q;
endmodule

// File: rtl/intc_event_detect.sv
module intc_event_detect #(
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_s,
  input  logic          rise_sel,
  input  logic [PW-1:0] port_s,
  input  logic          port_capture,
  output logic          ext_evt,
  output logic          port_evt
);
  logic          ext_prev_q, ext_prev_d;
  logic [PW-1:0] port_ref_q, port_ref_d;

  always_comb begin
    ext_prev_d = ext_s;
    port_ref_d = port_ref_q;
    if (port_capture) begin
      port_ref_d = port_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_prev_q <= 1'b0;
      port_ref_q <= '0;
    end else begin
      ext_prev_q <= ext_prev_d;
      port_ref_q <= port_ref_d;
    end
  end

  always_comb begin
    if (rise_sel) begin
      ext_evt = ext_s & ~ext_prev_q;
    end else begin
      ext_evt = ~ext_s & ext_prev_q;
    end
    port_evt = |(port_s ^ port_ref_q);
  end
endmodule

// File: rtl/intc_flag_bank.sv
module intc_flag_bank #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] flags
);
  logic [N-1:0] flag_q, flag_d;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_comb begin
      if (set_vec[i]) begin
        flag_d[i] = 1'b1;
      end else if (clr_vec[i]) begin
        flag_d[i] = 1'b0;
      end else begin
        flag_d[i] = flag_q[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign flags = flag_q;
endmodule

// File: rtl/intc_two_tier.sv
module intc_two_tier
  import intc_pkg::*;
#(
  parameter int NPER = 4,
  localparam int NSRC = CORE_SRCS + NPER,
  localparam int DW   = NSRC + 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ext_pin,
  input  logic [PORT_W-1:0]   port_pins,
  input  logic                tmr_wrap,
  input  logic [NPER-1:0]     periph_evt,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DW-1:0]       reg_wdata,
  output logic [DW-1:0]       reg_rdata,
  output logic                irq
);
  localparam int BIT_EDGE = NSRC;
  localparam int BIT_PGE  = NSRC + 1;
  localparam int BIT_GIE  = NSRC + 2;

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_pipe_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_pipe_q[1];

  // synchronisers
  logic              ext_s;
  logic [PORT_W-1:0] port_s;

  intc_sync #(.W(1)) u_sync_ext (
    .clk(clk), .rst_n(rst_core_n), .d_async(ext_pin), .q_sync(ext_s)
  );
  intc_sync #(.W(PORT_W)) u_sync_port (
    .clk(clk), .rst_n(rst_core_n), .d_async(port_pins), .q_sync(port_s)
  );

  // control register
  logic [NSRC-1:0] en_q, en_d;
  logic            rise_q, rise_d;
  logic            pge_q, pge_d;
  logic            gie_q, gie_d;
  logic            wr_ctrl, wr_flags, rd_port;

  assign wr_ctrl  = reg_wr && (reg_addr == ADR_CTRL);
  assign wr_flags = reg_wr && (reg_addr == ADR_FLAGS);
  assign rd_port  = reg_rd && (reg_addr == ADR_PORT);

  always_comb begin
    en_d   = en_q;
    rise_d = rise_q;
    pge_d  = pge_q;
    gie_d  = gie_q;
    if (wr_ctrl) begin
      en_d   = reg_wdata[NSRC-1:0];
      rise_d = reg_wdata[BIT_EDGE];
      pge_d  = reg_wdata[BIT_PGE];
      gie_d  = reg_wdata[BIT_GIE];
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      en_q   <= '0;
      rise_q <= 1'b0;
      pge_q  <= 1'b0;
      gie_q  <= 1'b0;
    end else begin
      en_q   <= en_d;
      rise_q <= rise_d;
      pge_q  <= pge_d;
      gie_q  <= gie_d;
    end
  end

  // event detection
  logic ext_evt, port_evt;

  intc_event_detect #(.PW(PORT_W)) u_detect (
    .clk(clk), .rst_n(rst_core_n),
    .ext_s(ext_s), .rise_sel(rise_q),
    .port_s(port_s), .port_capture(rd_port),
    .ext_evt(ext_evt), .port_evt(port_evt)
  );

  // flags
  logic [NSRC-1:0] set_vec, clr_vec, flags;

  always_comb begin
    set_vec = '0;
    set_vec[SRC_EXT]  = ext_evt;
    set_vec[SRC_PORT] = port_evt;
    set_vec[SRC_TMR]  = tmr_wrap;
    set_vec[NSRC-1:CORE_SRCS] = periph_evt;
    clr_vec = wr_flags ? ~reg_wdata[NSRC-1:0] : '0;
  end

  intc_flag_bank #(.N(NSRC)) u_flags (
    .clk(clk), .rst_n(rst_core_n),
    .set_vec(set_vec), .clr_vec(clr_vec), .flags(flags)
  );

  // qualification and request register
  logic [NSRC-1:0] gate_vec;
  logic            irq_d, irq_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_gate
    if (i < CORE_SRCS) begin : g_core
      assign gate_vec[i] = flags[i] & en_q[i] & gie_q;
    end else begin : g_periph
      assign gate_vec[i] = flags[i] & en_q[i] & gie_q & pge_q;
    end
  end

  assign irq_d = |gate_vec;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end
  assign irq = irq_q;

  // read mux
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADR_FLAGS: reg_rdata[NSRC-1:0] = flags;
      ADR_CTRL:  reg_rdata = {gie_q, pge_q, rise_q, en_q};
      ADR_PORT:  reg_rdata[PORT_W-1:0] = port_s;
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/intc_checker.sv
module intc_checker
  import intc_pkg::*;
#(
  parameter int NSRC = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            irq,
  input logic            reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [NSRC-1:0] flags,
  input logic [NSRC-1:0] set_vec,
  input logic [NSRC-1:0] en_q,
  input logic            gie_q,
  input logic            pge_q
);
  logic core_hit, periph_hit;
  assign core_hit   = |(flags[CORE_SRCS-1:0] & en_q[CORE_SRCS-1:0]);
  assign periph_hit = |(flags[NSRC-1:CORE_SRCS] & en_q[NSRC-1:CORE_SRCS]);

  // R1: a flag only falls after a write to the flag register
  a_r1_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(flags) & ~flags)) |-> $past(reg_wr && reg_addr == ADR_FLAGS));

  // R3: no request without the global enable one cycle earlier
  a_r3_global_gate: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(gie_q));

  // R5: a request raised by peripherals alone needs the group enable
  a_r5_periph_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !$past(core_hit)) |-> $past(pge_q));

  // R7: every event leaves its flag set, clear or not
  a_r7_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((flags & $past(set_vec)) == $past(set_vec)));

  // R10: qualifying condition produces a request on the next cycle
  a_r10_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (gie_q && (core_hit || (pge_q && periph_hit))) |=> irq);
endmodule

bind intc_two_tier intc_checker #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_core_n), .irq(irq), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .flags(flags), .set_vec(set_vec),
  .en_q(en_q), .gie_q(gie_q), .pge_q(pge_q)
);

// File: tb/tb_intc_two_tier.sv
module tb_intc_two_tier;
  localparam int CLK_PERIOD = 10;
  localparam int NPER = 4;
  localparam int NSRC = 7;
  localparam int DW   = 10;
  localparam logic [DW-1:0] GE   = 10'h200;
  localparam logic [DW-1:0] PGE  = 10'h100;
  localparam logic [DW-1:0] RISE = 10'h080;
  localparam int NVEC = 9;

  // {tmr, per[3:0], ctrl[9:0], irq, flags[6:0]}
  localparam logic [22:0] VEC [NVEC] = '{
    {1'b1, 4'b0000, 10'h000, 1'b0, 7'h04},
    {1'b1, 4'b0000, 10'h004, 1'b0, 7'h04},
    {1'b1, 4'b0000, 10'h204, 1'b1, 7'h04},
    {1'b0, 4'b0001, 10'h208, 1'b0, 7'h08},
    {1'b0, 4'b0001, 10'h308, 1'b1, 7'h08},
    {1'b0, 4'b0010, 10'h308, 1'b0, 7'h10},
    {1'b0, 4'b1000, 10'h140, 1'b0, 7'h40},
    {1'b1, 4'b0100, 10'h37F, 1'b1, 7'h24},
    {1'b1, 4'b0000, 10'h300, 1'b0, 7'h04}
  };

  logic            clk = 1'b0;
  logic            rst_n;
  logic            ext_pin;
  logic [3:0]      port_pins;
  logic            tmr_wrap;
  logic [NPER-1:0] periph_evt;
  logic            reg_wr, reg_rd;
  logic [1:0]      reg_addr;
  logic [DW-1:0]   reg_wdata;
  logic [DW-1:0]   reg_rdata;
  logic            irq;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intc_two_tier #(.NPER(NPER)) dut (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .port_pins(port_pins),
    .tmr_wrap(tmr_wrap), .periph_evt(periph_evt), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 2'd3;
  endtask

  task automatic peek(input logic [1:0] a, output logic [DW-1:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
    reg_addr = 2'd3;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [DW-1:0] rd;
    rst_n = 1'b0; ext_pin = 1'b0; port_pins = 4'h0; tmr_wrap = 1'b0;
    periph_evt = '0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = 2'd3; reg_wdata = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R11 reset state
    peek(2'd0, rd); check("R11 flags", 16'(rd), 16'h0);
    peek(2'd1, rd); check("R11 ctrl", 16'(rd), 16'h0);
    check("R11 irq", 16'(irq), 16'h0);

    // vector table: R2 R3 R4 R5 R11
    for (int v = 0; v < NVEC; v++) begin
      wr(2'd0, '0);
      wr(2'd1, VEC[v][17:8]);
      peek(2'd1, rd); check("R11 ctrl readback", 16'(rd), 16'(VEC[v][17:8]));
      tmr_wrap = VEC[v][22];
      periph_evt = VEC[v][21:18];
      @(negedge clk);
      tmr_wrap = 1'b0; periph_evt = '0;
      idle(2);
      peek(2'd0, rd); check("R3 flags set regardless of masks", 16'(rd), 16'(VEC[v][6:0]));
      check("R2/R4/R5 irq gating", 16'(irq), 16'(VEC[v][7]));
    end

    // R1 sticky, R10 held
    wr(2'd0, '0);
    wr(2'd1, GE | 10'h004);
    tmr_wrap = 1'b1; @(negedge clk); tmr_wrap = 1'b0;
    idle(10);
    peek(2'd0, rd); check("R1 flag sticky", 16'(rd), 16'h04);
    check("R10 irq held", 16'(irq), 16'h1);

    // R6 write-one keeps, write-zero clears; R10 drops a cycle later
    periph_evt = 4'b0001; @(negedge clk); periph_evt = '0;
    wr(2'd0, 10'h008);
    peek(2'd0, rd); check("R6 write one keeps, zero clears", 16'(rd), 16'h08);
    check("R10 irq still high at clear edge", 16'(irq), 16'h1);
    idle(1);
    check("R10 irq falls after condition ends", 16'(irq), 16'h0);
    wr(2'd0, 10'h000);

    // R7 event and clear in same cycle
    @(negedge clk);
    tmr_wrap = 1'b1; reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = '0;
    @(negedge clk);
    tmr_wrap = 1'b0; reg_wr = 1'b0; reg_addr = 2'd3;
    peek(2'd0, rd); check("R7 event wins over clear", 16'(rd), 16'h04);
    wr(2'd0, '0);

    // R8 edge select
    wr(2'd1, 10'h000);
    ext_pin = 1'b1; idle(5);
    peek(2'd0, rd); check("R8 rising ignored in falling mode", 16'(rd), 16'h00);
    ext_pin = 1'b0; idle(5);
    peek(2'd0, rd); check("R8 falling edge sets flag", 16'(rd), 16'h01);
    wr(2'd0, '0);
    wr(2'd1, RISE);
    ext_pin = 1'b1; idle(5);
    peek(2'd0, rd); check("R8 rising edge sets flag", 16'(rd), 16'h01);
    wr(2'd0, '0);
    ext_pin = 1'b0; idle(5);
    peek(2'd0, rd); check("R8 falling ignored in rising mode", 16'(rd), 16'h00);

    // R9 port change and reference reload
    port_pins = 4'b0101; idle(5);
    peek(2'd0, rd); check("R9 port change sets flag", 16'(rd), 16'h02);
    wr(2'd0, '0);
    peek(2'd0, rd); check("R9 flag returns while port differs", 16'(rd), 16'h02);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = 2'd2;
    #1 rd = reg_rdata;
    check("R9 port read value", 16'(rd), 16'h5);
    @(negedge clk);
    reg_rd = 1'b0; reg_addr = 2'd3;
    wr(2'd0, '0);
    idle(3);
    peek(2'd0, rd); check("R9 flag stays clear after reference reload", 16'(rd), 16'h00);

    finish_run();
  end
endmodule